// File: doc/BRIEF.md
# Phase-Staggered PWM Channel with Start Delay

This block generates one PWM waveform whose first period can be held back by a programmed number of clock cycles. When several copies run from one clock and each gets a different start delay, their periods interleave, and this gives multi-phase drive. The period is a power of two between 2^7 and 2^12 cycles. The duty value sets how many cycles of each period are high. Optional pulse spreading cuts the period into 4 or 32 equal slots and shares the high time among them.

The start delay is masked to the active resolution. When spreading is on, it is also clamped to the period divided by the slot count. The waveform leaves the block on one of two registered pins, selected by an alternate-route bit. The pin that is not selected stays low. All configuration inputs are sampled live on each clock. They are meant to change only while the channel is disabled.

Top module: `mpwm_channel`

## Requirements
- R1: While `rst` is high, and on the first clock after it, both `pwm_pri` and `pwm_alt` are low.
- R2: The effective resolution N is `res_sel` clamped to the range 7..12. The period is 2^N cycles.
- R3: Only bits [N-1:0] of `delay` take part in the start delay. Higher bits have no effect.
- R4: The `spread_sel` encoding is 00 none, 01 four slots, 10 thirty-two slots, and 11 treated as none. The masked delay is clamped to 2^N-1 with no spreading, 2^N/4 with four slots and 2^N/32 with thirty-two slots.
- R5: The rising edge that first samples `en` high starts the sequence. With an effective delay d, the selected pin stays low and first goes high d+1 cycles after that edge. That cycle is period count 0.
- R6: With no spreading, the output is high while the period count is below the duty value.
- R7: With S slots, the high time of duty D is floor(D/S) cycles at the start of every slot. The first D mod S slots get one more cycle each. In total, D cycles of each period are high.
- R8: A duty of 0 keeps the output low. A duty of 2^N-1 is high for all but one cycle of each period.
- R9: While `en` is sampled low, both outputs go low on the next edge. Raising `en` again restarts the full delay.
- R10: With `alt_sel`=1 the waveform appears on `pwm_alt` and `pwm_pri` stays low. With `alt_sel`=0 the reverse holds. The two outputs are never high together.
- R11: Only bits [N-1:0] of `duty` are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; a rising level starts the delay |
| res_sel | input | 4 | Requested resolution in bits |
| spread_sel | input | 2 | Pulse-spreading mode |
| duty | input | 12 | High cycles per period |
| delay | input | 12 | Start delay in cycles |
| alt_sel | input | 1 | Route the waveform to the alternate pin |
| pwm_pri | output | 1 | Primary pin output |
| pwm_alt | output | 1 | Alternate pin output |

## Verification
The bench drives delay values wider than the resolution, to catch a design that forgets the mask and starts far too late. It also drives values above the spreading limit, where a missing clamp gives a start that is too late. Resolution requests below 7 and above 12 exercise the clamp. A design without that clamp would produce a period of the wrong length and a wrong count of high cycles. Full-scale duty under 32-slot spreading checks the remainder placement, because a wrong distribution shifts high cycles into the wrong slot. Disabling mid-run and the alternate route expose outputs that linger, or a pin that is not selected but still toggles.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  typedef enum logic [1:0] {
    SPR_NONE = 2'b00,
    SPR_4    = 2'b01,
    SPR_32   = 2'b10,
    SPR_RSVD = 2'b11
  } spread_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_RUN  = 2'b10
  } seq_e;
endpackage

// File: rtl/mpwm_cfg.sv
module mpwm_cfg #(
  parameter int MAX_RES = 12,
  parameter int MIN_RES = 7,
  parameter int RW      = 4
) (
  input  logic [RW-1:0]      res_i,
  input  logic [1:0]         spread_i,
  input  logic [MAX_RES-1:0] duty_i,
  input  logic [MAX_RES-1:0] delay_i,
  output logic [RW-1:0]      res_o,
  output logic [2:0]         slot_log2_o,
  output logic [MAX_RES-1:0] pmax_o,
  output logic [MAX_RES-1:0] duty_o,
  output logic [MAX_RES-1:0] delay_o
);
  import mpwm_pkg::*;

  localparam logic [RW-1:0] RES_LO = RW'(MIN_RES);
  localparam logic [RW-1:0] RES_HI = RW'(MAX_RES);
  localparam logic [MAX_RES:0] ONE = (MAX_RES+1)'(1);

  logic [MAX_RES:0] period;
  logic [MAX_RES:0] full;
  logic [MAX_RES:0] lim;
  logic [MAX_RES-1:0] dly_m;

  always_comb begin
    if (res_i < RES_LO)      res_o = RES_LO;
    else if (res_i > RES_HI) res_o = RES_HI;
    else                     res_o = res_i;

    case (spread_e'(spread_i))
      SPR_4:   slot_log2_o = 3'd2;
      SPR_32:  slot_log2_o = 3'd5;
      default: slot_log2_o = 3'd0;
    endcase

    period = ONE << res_o;
    full   = period - ONE;
    lim    = (slot_log2_o == 3'd0) ? full : (period >> slot_log2_o);
    dly_m  = delay_i & full[MAX_RES-1:0];

    pmax_o  = full[MAX_RES-1:0];
    duty_o  = duty_i & full[MAX_RES-1:0];
    delay_o = ({1'b0, dly_m} > lim) ? lim[MAX_RES-1:0] : dly_m;
  end
endmodule

// File: rtl/mpwm_seq.sv
module mpwm_seq #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] delay_i,
  input  logic [W-1:0] pmax_i,
  output logic         run_o,
  output logic         wait_o,
  output logic [W-1:0] cnt_o
);
  import mpwm_pkg::*;

  seq_e         st_q;
  logic [W-1:0] dcnt_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q   <= ST_IDLE;
      dcnt_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (delay_i == '0) begin
            st_q <= ST_RUN;
          end else begin
            st_q   <= ST_WAIT;
            dcnt_q <= delay_i;
          end
        end
        ST_WAIT: begin
          if (dcnt_q <= W'(1)) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end else begin
            dcnt_q <= dcnt_q - W'(1);
          end
        end
        ST_RUN:  cnt_q <= (cnt_q >= pmax_i) ? '0 : cnt_q + W'(1);
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (st_q == ST_RUN);
  assign wait_o = (st_q == ST_WAIT);
  assign cnt_o  = cnt_q;

  // R5
  wait_to_run_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && dcnt_q == W'(1) && en) |=> (st_q == ST_RUN && cnt_q == '0));

  // R9
  idle_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (st_q == ST_IDLE));
endmodule

// File: rtl/mpwm_wave.sv
module mpwm_wave #(
  parameter int W  = 12,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic [W-1:0]  cnt_i,
  input  logic [RW-1:0] res_i,
  input  logic [2:0]    slot_log2_i,
  input  logic [W-1:0]  duty_i,
  output logic          hi_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0]  base;
  logic [W-1:0]  rem;
  logic [RW-1:0] shamt;
  logic [W-1:0]  slot_idx;
  logic [W-1:0]  offs;
  logic [W:0]    slot_hi;

  always_comb begin
    base     = duty_i >> slot_log2_i;
    rem      = duty_i & ((ONE << slot_log2_i) - ONE);
    shamt    = res_i - RW'(slot_log2_i);
    slot_idx = cnt_i >> shamt;
    offs     = cnt_i & ((ONE << shamt) - ONE);
    slot_hi  = {1'b0, base} + ((slot_idx < rem) ? (W+1)'(1) : (W+1)'(0));
    hi_o     = run_i && ({1'b0, offs} < slot_hi);
  end

  // R8
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
    (duty_i == '0) |-> !hi_o);
endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel #(
  parameter int MAX_RES = 12,
  parameter int MIN_RES = 7,
  parameter int RW      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [RW-1:0]      res_sel,
  input  logic [1:0]         spread_sel,
  input  logic [MAX_RES-1:0] duty,
  input  logic [MAX_RES-1:0] delay,
  input  logic               alt_sel,
  output logic               pwm_pri,
  output logic               pwm_alt
);
  logic [RW-1:0]      res_n;
  logic [2:0]         slot_log2;
  logic [MAX_RES-1:0] pmax;
  logic [MAX_RES-1:0] duty_m;
  logic [MAX_RES-1:0] delay_m;
  logic               run;
  logic               waiting;
  logic [MAX_RES-1:0] cnt;
  logic               hi;
  logic               pri_q;
  logic               alt_q;

  mpwm_cfg #(.MAX_RES(MAX_RES), .MIN_RES(MIN_RES), .RW(RW)) u_cfg (
    .res_i(res_sel), .spread_i(spread_sel), .duty_i(duty), .delay_i(delay),
    .res_o(res_n), .slot_log2_o(slot_log2), .pmax_o(pmax),
    .duty_o(duty_m), .delay_o(delay_m)
  );

  mpwm_seq #(.W(MAX_RES)) u_seq (
    .clk(clk), .rst(rst), .en(en), .delay_i(delay_m), .pmax_i(pmax),
    .run_o(run), .wait_o(waiting), .cnt_o(cnt)
  );

  mpwm_wave #(.W(MAX_RES), .RW(RW)) u_wave (
    .clk(clk), .rst(rst), .run_i(run), .cnt_i(cnt), .res_i(res_n),
    .slot_log2_i(slot_log2), .duty_i(duty_m), .hi_o(hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q <= 1'b0;
      alt_q <= 1'b0;
    end else begin
      pri_q <= en && hi && !alt_sel;
      alt_q <= en && hi && alt_sel;
    end
  end

  assign pwm_pri = pri_q;
  assign pwm_alt = alt_q;

  // R10
  one_pin_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pri_q, alt_q}));

  // R9
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pri_q && !alt_q));

  // R5
  low_during_wait_chk: assert property (@(posedge clk) disable iff (rst)
    waiting |=> (!pri_q && !alt_q));
endmodule

// File: tb/sim_mpwm_channel.sv
module sim_mpwm_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [3:0]  res_sel = 4'd8;
  logic [1:0]  spread_sel = 2'b00;
  logic [11:0] duty = '0;
  logic [11:0] delay = '0;
  logic        alt_sel = 1'b0;
  logic        pwm_pri;
  logic        pwm_alt;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  mpwm_channel u0 (
    .clk(clk), .rst(rst), .en(en), .res_sel(res_sel), .spread_sel(spread_sel),
    .duty(duty), .delay(delay), .alt_sel(alt_sel),
    .pwm_pri(pwm_pri), .pwm_alt(pwm_alt)
  );

  function automatic int eff_res(int r);
    if (r < 7) return 7;
    if (r > 12) return 12;
    return r;
  endfunction

  function automatic int slots(int sp);
    if (sp == 1) return 4;
    if (sp == 2) return 32;
    return 1;
  endfunction

  function automatic int eff_delay(int r, int sp, int d);
    int p, m, lim;
    p = 1 << eff_res(r);
    m = d % p;
    lim = (slots(sp) == 1) ? p - 1 : p / slots(sp);
    return (m > lim) ? lim : m;
  endfunction

  function automatic bit wave_ref(int c, int r, int sp, int d);
    int p, s, dm, len, hi_cnt;
    p = 1 << eff_res(r);
    s = slots(sp);
    dm = d % p;
    if (s == 1) return c < dm;
    len = p / s;
    hi_cnt = dm / s + (((c / len) < (dm % s)) ? 1 : 0);
    return (c % len) < hi_cnt;
  endfunction

  // Behavioural reference, stepped on every rising edge
  int m_st = 0, m_dc = 0, m_cnt = 0;
  bit m_pri = 0, m_alt = 0;
  always @(posedge clk) begin
    bit h;
    if (rst) begin
      m_st = 0; m_dc = 0; m_cnt = 0; m_pri = 0; m_alt = 0;
    end else begin
      h = en && (m_st == 2) && wave_ref(m_cnt, res_sel, spread_sel, duty);
      m_pri = h && !alt_sel;
      m_alt = h && alt_sel;
      if (!en) begin
        m_st = 0; m_dc = 0; m_cnt = 0;
      end else if (m_st == 0) begin
        m_dc = eff_delay(res_sel, spread_sel, delay);
        m_cnt = 0;
        m_st = (m_dc == 0) ? 2 : 1;
      end else if (m_st == 1) begin
        if (m_dc <= 1) begin m_st = 2; m_cnt = 0; end
        else m_dc = m_dc - 1;
      end else begin
        m_cnt = (m_cnt >= (1 << eff_res(res_sel)) - 1) ? 0 : m_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) chk({pwm_pri, pwm_alt} == {m_pri, m_alt}, tag,
                  {pwm_pri, pwm_alt}, {m_pri, m_alt});
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic run_case(input int r, input int sp, input int d, input int dl,
                          input int a, input string t);
    int p, dd, dm, first, highs;
    bit o;
    p = 1 << eff_res(r);
    dd = eff_delay(r, sp, dl);
    dm = d % p;
    @(negedge clk);
    tag = t;
    res_sel = 4'(r); spread_sel = 2'(sp); duty = 12'(d); delay = 12'(dl);
    alt_sel = a[0]; en = 1'b1;
    first = -1; highs = 0;
    for (int i = 0; i < dd + 1 + 2 * p; i++) begin
      @(negedge clk);
      o = a[0] ? pwm_alt : pwm_pri;
      if (o && first < 0) first = i;
      if (first >= 0 && i < first + p && o) highs++;
    end
    if (dm > 0) begin
      chk(first == dd + 1, {t, " first high"}, first, dd + 1);
      chk(highs == dm, {t, " highs per period"}, highs, dm);
    end else begin
      chk(first == -1, {t, " never high"}, first, -1);
    end
    en = 1'b0;
    @(negedge clk);
    chk(!pwm_pri && !pwm_alt, "R9 off after disable", {pwm_pri, pwm_alt}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pwm_pri && !pwm_alt, "R1 reset low", {pwm_pri, pwm_alt}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!pwm_pri && !pwm_alt, "R1 after reset", {pwm_pri, pwm_alt}, 0);

    run_case(8, 0, 100, 12'h1F0, 0, "R3 R6 delay mask");
    run_case(8, 1, 130, 200, 0, "R4 R7 four-slot clamp");
    run_case(7, 2, 127, 100, 0, "R7 R8 thirty-two-slot full");
    run_case(3, 0, 12'h1FF, 0, 1, "R2 R10 low res alt");
    run_case(8, 0, 0, 5, 1, "R8 zero duty");
    run_case(15, 0, 12'hABC, 12'hFFF, 0, "R2 R6 high res");
    run_case(10, 3, 300, 1023, 1, "R4 reserved mode");
    run_case(9, 1, 12'h3FF, 0, 0, "R11 R8 duty mask");

    // R9: drop enable mid-run, then restart with full delay
    @(negedge clk);
    tag = "R9 mid-run";
    res_sel = 4'd8; spread_sel = 2'b00; duty = 12'd50; delay = 12'd10; alt_sel = 1'b0;
    en = 1'b1;
    repeat (100) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!pwm_pri && !pwm_alt, "R9 mid-run off", {pwm_pri, pwm_alt}, 0);
    run_case(8, 0, 50, 10, 0, "R9 R5 restart");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule